// File: doc/BRIEF.md
# Encoded Interrupt Level Input Filter

This block sits between four external interrupt pins and a processor core. The pins carry an interrupt level encoded active-low. The block moves the pins into the core clock domain and rejects short glitches. It then decodes the surviving code into a priority level, and asserts a request for as long as that level is non-zero. The request is not stored. It follows the filtered pin code on every cycle, so an external source must hold its code until the core has taken the interrupt.

When the core accepts a request, it pulses an acknowledge. The block then masks the code that is still on the pins, so the same held level is not taken a second time. The core also reports when it is in an external vector fetch cycle. The block turns the start of each such cycle into a single-cycle strobe, which the external device can use to clear its interrupt source.

Top module: `irl_level_filter`

## Requirements
- R1: While reset is high and at the first sample after it, req_valid, req_level and vec_clr are all 0, and the filtered code is 1111 (idle).
- R2: The decoded level is the bitwise inverse of the filtered 4-bit code. 1111 gives level 0 (no request), 1101 gives level 2 and 1001 gives level 6.
- R3: A new pin code that stays steady reaches the outputs just after the fourth rising edge, counting the first edge that samples it. The outputs do not change before that edge.
- R4: A different code that is on the pins for only one clock never changes req_level or req_valid.
- R5: No request is latched. When the pins return to 1111, req_valid falls with the same latency as in R3.
- R6: If ack is high at an edge where req_valid is high, req_valid and req_level are 0 from that edge on, for as long as the filtered code stays the same.
- R7: After an acknowledge, the request is asserted again with the normal latency in two cases: the filtered code changes to a different non-idle code, or it goes idle and the same code then returns.
- R8: An ack at an edge where req_valid is low has no effect. A later non-idle code raises the request normally.
- R9: vec_clr is high for exactly one cycle, after the edge that first samples vec_fetch high. If vec_fetch stays high, no further pulse follows.
- R10: req_valid is high exactly when req_level is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| irl_pins_n | input | 4 | Encoded interrupt level from the pins, active-low |
| ack | input | 1 | Core has accepted the current request |
| vec_fetch | input | 1 | Core is in an external vector fetch cycle |
| req_level | output | 4 | Decoded request level, 0 when no request is valid |
| req_valid | output | 1 | Request to the core |
| vec_clr | output | 1 | One-cycle strobe at the start of a vector fetch |

## Verification
A pin change reaches req_level and req_valid on the fourth edge that samples it: two synchroniser flops, one compare flop and the filtered register. An acknowledge masks the request from the very edge at which it is sampled, and vec_clr follows vec_fetch by one edge. The reference model in the bench keeps a history of pin samples taken at each edge and applies these rules to that history. The bench compares every output at the falling edge, after all registers have settled. The directed checks sample at the third and the fourth edge after a change, so that both an early and a late result are reported.

// File: rtl/irl_pkg.sv
package irl_pkg;
  localparam int IRL_W = 4;
  localparam logic [IRL_W-1:0] IDLE_CODE = '1;

  // Active-low code to priority level
  function automatic logic [IRL_W-1:0] code_to_level(input logic [IRL_W-1:0] code);
    return ~code;
  endfunction

  // Saturating increment of a run counter
  function automatic int unsigned sat_inc(input int unsigned v, input int unsigned lim);
    return (v >= lim) ? lim : v + 1;
  endfunction
endpackage

// File: rtl/irl_sync.sv
module irl_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= RST_VAL;
    else     stg[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[i] <= RST_VAL;
      else     stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/irl_glitch_filter.sv
module irl_glitch_filter #(
  parameter int W      = 4,
  parameter int STABLE = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] samp,
  output logic [W-1:0] filt
);
  localparam int CNT_W = $clog2(STABLE + 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(STABLE);
  localparam logic [CNT_W-1:0] CNT_NEED = CNT_W'(STABLE - 2);

  logic [W-1:0]     prev_samp;
  logic [CNT_W-1:0] run_cnt;
  logic             same;
  logic             accept;

  assign same   = (samp == prev_samp);
  assign accept = same && (run_cnt >= CNT_NEED);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_samp <= '1;
      run_cnt   <= CNT_MAX;
      filt      <= '1;
    end else begin
      prev_samp <= samp;
      if (same) run_cnt <= CNT_W'(irl_pkg::sat_inc(int'(run_cnt), STABLE));
      else      run_cnt <= '0;
      if (accept) filt <= samp;
    end
  end
endmodule

// File: rtl/irl_ack_gate.sv
module irl_ack_gate #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] filt_code,
  input  logic         ack,
  output logic [W-1:0] req_level,
  output logic         req_valid,
  output logic         ack_taken
);
  logic [W-1:0] level;
  logic [W-1:0] blk_code;
  logic         blocked;
  logic         suppressed;

  assign level      = irl_pkg::code_to_level(filt_code);
  assign suppressed = blocked && (filt_code == blk_code);
  assign req_valid  = (level != '0) && !suppressed;
  assign req_level  = req_valid ? level : '0;
  assign ack_taken  = ack && req_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      blocked  <= 1'b0;
      blk_code <= '1;
    end else if (ack_taken) begin
      blocked  <= 1'b1;
      blk_code <= filt_code;
    end else if (filt_code != blk_code) begin
      blocked  <= 1'b0;
    end
  end
endmodule

// File: rtl/irl_fetch_strobe.sv
module irl_fetch_strobe (
  input  logic clk,
  input  logic rst,
  input  logic fetch,
  output logic pulse
);
  logic fetch_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      fetch_d <= 1'b0;
      pulse   <= 1'b0;
    end else begin
      fetch_d <= fetch;
      pulse   <= fetch && !fetch_d;
    end
  end
endmodule

// File: rtl/irl_level_filter.sv
module irl_level_filter #(
  parameter int SYNC_STAGES    = 2,
  parameter int STABLE_SAMPLES = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [irl_pkg::IRL_W-1:0] irl_pins_n,
  input  logic                      ack,
  input  logic                      vec_fetch,
  output logic [irl_pkg::IRL_W-1:0] req_level,
  output logic                      req_valid,
  output logic                      vec_clr
);
  localparam int W = irl_pkg::IRL_W;

  logic [W-1:0] sync_q;
  logic [W-1:0] filt_code;
  logic         ack_taken;

  irl_sync #(.W(W), .STAGES(SYNC_STAGES), .RST_VAL(irl_pkg::IDLE_CODE)) u_sync (
    .clk(clk), .rst(rst), .d(irl_pins_n), .q(sync_q)
  );

  irl_glitch_filter #(.W(W), .STABLE(STABLE_SAMPLES)) u_filt (
    .clk(clk), .rst(rst), .samp(sync_q), .filt(filt_code)
  );

  irl_ack_gate #(.W(W)) u_gate (
    .clk(clk), .rst(rst), .filt_code(filt_code), .ack(ack),
    .req_level(req_level), .req_valid(req_valid), .ack_taken(ack_taken)
  );

  irl_fetch_strobe u_strobe (
    .clk(clk), .rst(rst), .fetch(vec_fetch), .pulse(vec_clr)
  );
endmodule

// File: rtl/irl_level_filter_chk.sv
module irl_level_filter_chk (
  input logic       clk,
  input logic       rst,
  input logic       ack,
  input logic       vec_fetch,
  input logic [3:0] req_level,
  input logic       req_valid,
  input logic       vec_clr,
  input logic [3:0] sync_q,
  input logic [3:0] filt_code,
  input logic       ack_taken
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!req_valid && !vec_clr && filt_code == 4'hF));

  assert_valid_matches_level_R10: assert property (@(posedge clk) disable iff (rst)
    req_valid == (req_level != 4'h0));

  assert_filter_needs_steady_R4: assert property (@(posedge clk) disable iff (rst)
    (filt_code != $past(filt_code)) |->
      (filt_code == $past(sync_q) && $past(sync_q) == $past(sync_q, 2)));

  assert_ack_masks_R6: assert property (@(posedge clk) disable iff (rst)
    ack_taken |=> (!req_valid || filt_code != $past(filt_code)));

  assert_new_code_requests_R7: assert property (@(posedge clk) disable iff (rst)
    (filt_code != $past(filt_code) && filt_code != 4'hF) |-> req_valid);

  assert_strobe_single_R9: assert property (@(posedge clk) disable iff (rst)
    vec_clr |=> !vec_clr);

  assert_strobe_cause_R9: assert property (@(posedge clk) disable iff (rst)
    vec_clr |-> $past(vec_fetch));
endmodule

bind irl_level_filter irl_level_filter_chk u_chk (.*);

// File: tb/irl_level_filter_test.sv
module irl_level_filter_test;
  localparam int CLK_PERIOD = 10;
  localparam int STABLE = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] pins = 4'hF;
  logic ack = 1'b0;
  logic fetch = 1'b0;
  logic [3:0] req_level;
  logic req_valid;
  logic vec_clr;

  int checks = 0;
  int fails = 0;
  bit cmp_on = 1'b0;
  bit finished = 1'b0;
  string tag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  irl_level_filter uut (
    .clk(clk), .rst(rst), .irl_pins_n(pins), .ack(ack), .vec_fetch(fetch),
    .req_level(req_level), .req_valid(req_valid), .vec_clr(vec_clr)
  );

  // Reference model: a history of pin samples, one entry per edge
  logic [3:0] hist [8];
  logic [3:0] m_filt = 4'hF;
  logic [3:0] m_bcode = 4'hF;
  bit m_blk = 0, m_prev = 0, m_clr = 0;

  function automatic int exp_level();
    if (m_blk && m_filt == m_bcode) return 0;
    return 15 - int'(m_filt);
  endfunction

  initial for (int i = 0; i < 8; i++) hist[i] = 4'hF;

  always @(posedge clk) begin
    logic [3:0] f_old;
    int v_old;
    bit same;
    if (rst) begin
      for (int i = 0; i < 8; i++) hist[i] = 4'hF;
      m_filt = 4'hF; m_bcode = 4'hF; m_blk = 0; m_prev = 0; m_clr = 0;
    end else begin
      f_old = m_filt;
      v_old = exp_level();
      same = 1;
      for (int i = 2; i <= STABLE; i++) if (hist[i] != hist[1]) same = 0;
      if (same) m_filt = hist[1];
      if (ack && v_old != 0) begin
        m_blk = 1; m_bcode = f_old;
      end else if (f_old != m_bcode) m_blk = 0;
      m_clr = fetch && !m_prev;
      m_prev = fetch;
      for (int i = 7; i > 0; i--) hist[i] = hist[i-1];
      hist[0] = pins;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model, at the falling edge
  always @(negedge clk) begin
    if (cmp_on && !finished) begin
      chk({tag, " req_level"}, int'(req_level), exp_level());
      chk({tag, " req_valid"}, int'(req_valid), int'(exp_level() != 0));
      chk({tag, " vec_clr"}, int'(vec_clr), int'(m_clr));
      chk("R10 valid vs level", int'(req_valid), int'(req_level != 0));
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int unsigned seed;
    int hold;
    logic [3:0] base;
    step(3);
    chk("R1 valid in reset", int'(req_valid), 0);
    chk("R1 vec_clr in reset", int'(vec_clr), 0);
    rst = 1'b0;
    step(1);
    chk("R1 level after reset", int'(req_level), 0);
    cmp_on = 1'b1;
    step(2);

    tag = "R3";
    pins = 4'b1101;
    step(3);
    chk("R3 no early change", int'(req_valid), 0);
    step(1);
    chk("R3 R2 level 2 on fourth edge", int'(req_level), 2);
    step(2);

    tag = "R4";
    pins = 4'b1011;
    step(1);
    pins = 4'b1101;
    for (int i = 0; i < 6; i++) begin
      step(1);
      chk("R4 glitch ignored", int'(req_level), 2);
    end

    tag = "R2";
    pins = 4'b1001;
    step(4);
    chk("R2 level 6", int'(req_level), 6);

    tag = "R5";
    pins = 4'b1111;
    step(3);
    chk("R5 still high before latency", int'(req_valid), 1);
    step(1);
    chk("R5 request drops", int'(req_valid), 0);

    tag = "R6";
    pins = 4'b1101;
    step(5);
    chk("R6 valid before ack", int'(req_valid), 1);
    ack = 1'b1;
    step(1);
    ack = 1'b0;
    chk("R6 masked after ack", int'(req_valid), 0);
    step(4);
    chk("R6 stays masked", int'(req_level), 0);

    tag = "R7";
    pins = 4'b1001;
    step(4);
    chk("R7 new code reasserts", int'(req_level), 6);
    ack = 1'b1;
    step(1);
    ack = 1'b0;
    pins = 4'b1111;
    step(5);
    chk("R7 idle", int'(req_valid), 0);
    pins = 4'b1001;
    step(4);
    chk("R7 same code after idle", int'(req_level), 6);

    tag = "R8";
    pins = 4'b1111;
    step(5);
    ack = 1'b1;
    step(1);
    ack = 1'b0;
    pins = 4'b1001;
    step(4);
    chk("R8 ack while idle ignored", int'(req_level), 6);

    tag = "R9";
    fetch = 1'b1;
    step(1);
    chk("R9 strobe", int'(vec_clr), 1);
    step(1);
    chk("R9 single pulse", int'(vec_clr), 0);
    step(2);
    fetch = 1'b0;
    step(2);
    chk("R9 no pulse on fall", int'(vec_clr), 0);

    tag = "R10 random";
    seed = 32'h1234_5678;
    base = 4'hF;
    hold = 0;
    for (int c = 0; c < 3000; c++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      if (hold == 0) begin
        base = (seed[20:18] == 3'd0) ? 4'hF : seed[27:24];
        hold = 1 + int'(seed[15:12]);
      end
      hold--;
      pins = (seed[30:28] == 3'd0) ? seed[11:8] : base;
      ack = (seed[6:4] == 3'd0);
      fetch = seed[2] & seed[1];
      step(1);
    end
    ack = 1'b0;
    fetch = 1'b0;
    step(2);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      fails++;
      checks++;
      $display("FAIL watchdog R1..: run did not complete actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule